// File: doc/BRIEF.md
# Latched Status Change Interrupt Unit

This block watches a set of live status lines from four channels, seven lines per channel. When an enabled line changes, the block freezes that bit at its new value and raises a summary interrupt. The interrupt is shared by all channels. It is reported as a plain flag, as bit 7 of the mask readback, and on an active-low pin. A host finds out what happened by reading a channel. The read returns the frozen word, clears that channel's pending bits and lets them follow the live lines again. One 7-bit mask is shared by all channels and decides which bit positions can raise the interrupt.

Live inputs are treated as asynchronous. They pass through a two-stage synchronizer, and the block compares the synchronized value with its value one cycle earlier to find changes.

All ports are plain control and status signals. A read is a single-cycle strobe with no back-pressure: the block accepts a strobe on every cycle. A mask write is likewise a single-cycle enable.

Top module: `lt_irq_unit`

## Requirements
- R1: After reset the mask is all ones (every bit masked), `irq_flag_o` is 0, `irq_n_o` is 1, `rd_data_o` is 0 and `mask_rd_o` is 8'h7F.
- R2: A change on live bit b of channel c, with mask bit b clear, latches that bit and raises `irq_flag_o`. The flag is visible after the third rising edge that follows the change on `live_i`: two synchronizer stages plus the latch.
- R3: While a bit is latched it keeps its captured value, whatever the live line does, until its channel is read.
- R4: A read is `rd_stb_i` high with channel number `rd_ch_i`. The word held for that channel appears on `rd_data_o` after that edge and stays there until the next read. At the same edge the channel's latches clear, and every bit takes its current synchronized live value.
- R5: The interrupt stays asserted until every channel that holds a latched, unmasked bit has been read. Reading one channel leaves the pending bits of the others untouched.
- R6: A change on a masked bit position latches nothing and raises no interrupt. That bit follows its synchronized live value in the read data.
- R7: `mask_we_i` high loads `mask_wdata_i[6:0]` into the mask at that edge. Mask bit n set to 1 masks status bit n in all channels. `mask_rd_o[6:0]` shows the mask, and `mask_rd_o[7]` shows the interrupt flag.
- R8: `irq_n_o` is the active-low form of `irq_flag_o`: it is low exactly when an interrupt is pending.
- R9: An unmasked change that reaches the edge detector on the same edge as a read of its channel is not lost. The bit re-latches at that edge, and the flag remains asserted in the next cycle.
- R10: Setting a mask bit over a latched bit takes that bit out of the interrupt without clearing the latch. Clearing the mask bit again, before any read, makes it count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_i | input | NCH*NB (28) | Live status lines; channel c occupies bits [c*NB +: NB] |
| rd_stb_i | input | 1 | Read strobe, one cycle per read |
| rd_ch_i | input | CHW (2) | Channel selected by the read |
| mask_we_i | input | 1 | Mask write enable |
| mask_wdata_i | input | NB (7) | New mask value |
| rd_data_o | output | NB (7) | Status word returned by the last read |
| mask_rd_o | output | NB+1 (8) | {interrupt flag, mask} |
| irq_flag_o | output | 1 | Summary interrupt, active high |
| irq_n_o | output | 1 | Summary interrupt pin, active low |

## Verification
A change on a live line becomes a latched bit and an interrupt after the third rising edge. A read or a mask write takes effect on `rd_data_o`, the flag and `mask_rd_o` after the edge that samples it. The bench drives inputs on falling edges. A behavioural reference model keeps a three-deep history of the live inputs and applies the same latencies. The bench compares every output against this model on each falling edge. The directed checks wait exactly those edge counts before sampling. The R9 case is timed so that the detected change lands on the edge that samples the read strobe.

// File: rtl/lt_irq_pkg.sv
package lt_irq_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned LT_NCH = 4;   // channels
  localparam int unsigned LT_NB  = 7;   // status bits per channel

  // width of a channel number, at least one bit
  function automatic int unsigned ch_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lt_sync_edge.sv
// Two-stage synchronizer followed by a change detector.
module lt_sync_edge #(
  parameter int unsigned W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] chg_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign cur_o = sync_q;
  assign chg_o = sync_q ^ prev_q;
endmodule

// File: rtl/lt_mask_reg.sv
// Global mask shared by every channel.
module lt_mask_reg #(
  parameter int unsigned NB = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [NB-1:0] wdata_i,
  output logic [NB-1:0] mask_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [NB-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '1;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mask_q == $past(wdata_i)));
  assert_mask_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mask_q));
endmodule

// File: rtl/lt_chan.sv
// One channel: latch-on-change status word with read-to-clear.
module lt_chan #(
  parameter int unsigned NB = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] cur_i,    // synchronized live value
  input  logic [NB-1:0] chg_i,    // changed this cycle
  input  logic [NB-1:0] mask_i,
  input  logic          rd_i,     // this channel is read now
  output logic [NB-1:0] stat_o,
  output logic [NB-1:0] lt_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [NB-1:0] stat_q, lt_q, hit;

  assign hit = chg_i & ~mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      lt_q   <= '0;
    end else if (rd_i) begin
      stat_q <= cur_i;
      lt_q   <= hit;               // same-cycle change re-latches
    end else begin
      stat_q <= (stat_q & lt_q) | (cur_i & ~lt_q);
      lt_q   <= lt_q | hit;
    end
  end

  assign stat_o = stat_q;
  assign lt_o   = lt_q;

  assert_latch_on_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chg_i & ~mask_i)) |=>
      ((lt_q & $past(chg_i & ~mask_i)) == $past(chg_i & ~mask_i)));
  assert_hold_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (((stat_q ^ $past(stat_q)) & $past(lt_q)) == '0));
  assert_read_refresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> ((stat_q == $past(cur_i)) &&
              ((lt_q & ~$past(chg_i & ~mask_i)) == '0)));
  assert_masked_no_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((lt_q & ~$past(lt_q) & $past(mask_i)) == '0));
endmodule

// File: rtl/lt_irq_unit.sv
module lt_irq_unit
  import lt_irq_pkg::*;
#(
  parameter int unsigned NCH = LT_NCH,
  parameter int unsigned NB  = LT_NB,
  parameter int unsigned CHW = ch_width(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*NB-1:0] live_i,
  input  logic              rd_stb_i,
  input  logic [CHW-1:0]    rd_ch_i,
  input  logic              mask_we_i,
  input  logic [NB-1:0]     mask_wdata_i,
  output logic [NB-1:0]     rd_data_o,
  output logic [NB:0]       mask_rd_o,
  output logic              irq_flag_o,
  output logic              irq_n_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned W = NCH * NB;

  logic [W-1:0]   cur, chg;
  logic [NB-1:0]  mask;
  logic [NB-1:0]  stat_a [NCH];
  logic [NB-1:0]  lt_a   [NCH];
  logic [NCH-1:0] pend_v, lt_any_v;
  logic [NB-1:0]  sel_stat, rd_q;

  lt_sync_edge #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(live_i), .cur_o(cur), .chg_o(chg)
  );

  lt_mask_reg #(.NB(NB)) u_mask (
    .clk(clk), .rst_n(rst_n), .we_i(mask_we_i), .wdata_i(mask_wdata_i),
    .mask_o(mask)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic rd_c;
    assign rd_c = rd_stb_i && (rd_ch_i == CHW'(c));
    lt_chan #(.NB(NB)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .cur_i(cur[c*NB +: NB]), .chg_i(chg[c*NB +: NB]),
      .mask_i(mask), .rd_i(rd_c),
      .stat_o(stat_a[c]), .lt_o(lt_a[c])
    );
    assign pend_v[c]   = |(lt_a[c] & ~mask);
    assign lt_any_v[c] = |lt_a[c];
  end

  always_comb begin
    sel_stat = '0;
    for (int c = 0; c < NCH; c++)
      if (rd_ch_i == CHW'(c)) sel_stat = stat_a[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_q <= '0;
    else if (rd_stb_i) rd_q <= sel_stat;
  end

  assign rd_data_o  = rd_q;
  assign irq_flag_o = |pend_v;
  assign irq_n_o    = ~(|pend_v);
  assign mask_rd_o  = {irq_flag_o, mask};

  assert_read_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> (rd_data_o == $past(sel_stat)));
  assert_read_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> $stable(rd_data_o));
  assert_pin_needs_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> (|lt_any_v));
endmodule

// File: tb/lt_irq_unit_test.sv
module lt_irq_unit_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NCH = 4;
  localparam int NB  = 7;
  localparam int W   = NCH * NB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0]  live = '0;
  logic          rd_stb = 1'b0;
  logic [1:0]    rd_ch = '0;
  logic          mask_we = 1'b0;
  logic [NB-1:0] mask_wdata = '0;
  logic [NB-1:0] rd_data;
  logic [NB:0]   mask_rd;
  logic          irq_flag, irq_n;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  lt_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .live_i(live), .rd_stb_i(rd_stb), .rd_ch_i(rd_ch),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .rd_data_o(rd_data),
    .mask_rd_o(mask_rd), .irq_flag_o(irq_flag), .irq_n_o(irq_n)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [NB-1:0] m_hv [NCH];
  logic [NB-1:0] m_lt [NCH];
  logic [NB-1:0] m_mask = '1;
  logic [NB-1:0] m_rd = '0;
  logic [W-1:0]  hist [$];   // hist[0] newest live sample
  logic [W-1:0]  m_cur, m_diff;
  logic [NB-1:0] cv, hv;

  initial begin
    for (int c = 0; c < NCH; c++) begin m_hv[c] = '0; m_lt[c] = '0; end
    for (int i = 0; i < 3; i++) hist.push_back('0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin m_hv[c] = '0; m_lt[c] = '0; end
      m_mask = '1;
      m_rd = '0;
      for (int i = 0; i < 3; i++) hist[i] = '0;
    end else begin
      m_cur  = hist[1];
      m_diff = hist[1] ^ hist[2];
      for (int c = 0; c < NCH; c++) begin
        cv = m_cur[c*NB +: NB];
        hv = m_diff[c*NB +: NB] & ~m_mask;
        if (rd_stb && rd_ch == c) begin
          m_rd = m_hv[c];
          m_hv[c] = cv;
          m_lt[c] = hv;
        end else begin
          for (int b = 0; b < NB; b++)
            if (!m_lt[c][b]) begin
              m_hv[c][b] = cv[b];
              if (hv[b]) m_lt[c][b] = 1'b1;
            end
        end
      end
      if (mask_we) m_mask = mask_wdata;
      hist.push_front(live);
      void'(hist.pop_back());
    end
  end

  function automatic bit exp_flag();
    bit f = 1'b0;
    for (int c = 0; c < NCH; c++) if ((m_lt[c] & ~m_mask) != '0) f = 1'b1;
    return f;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3/R4 rd_data", rd_data, m_rd);
      check("R2/R5 irq_flag", irq_flag, exp_flag());
      check("R8 irq_n", irq_n, !exp_flag());
      check("R7 mask_rd", mask_rd, {exp_flag(), m_mask});
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic rd(int c);
    rd_stb = 1'b1; rd_ch = 2'(c);
    tick(1);
    rd_stb = 1'b0;
  endtask
  task automatic wmask(logic [NB-1:0] v);
    mask_we = 1'b1; mask_wdata = v;
    tick(1);
    mask_we = 1'b0;
  endtask
  task automatic setb(int c, int b, logic v);
    live[c*NB + b] = v;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 mask", mask_rd, 8'h7F);
    check("R1 irq_n", irq_n, 1);
    check("R1 flag", irq_flag, 0);
    check("R1 rd_data", rd_data, 0);

    // masked change: no latch, value tracks
    setb(0, 0, 1'b1); tick(5);
    check("R6 flag", irq_flag, 0);
    rd(0);
    check("R6 rd_data", rd_data, 7'h01);

    wmask('0);
    check("R7 mask cleared", mask_rd, 8'h00);

    // latency of latch
    setb(1, 3, 1'b1); tick(2);
    check("R2 flag early", irq_flag, 0);
    tick(1);
    check("R2 flag due", irq_flag, 1);
    check("R8 pin low", irq_n, 0);

    // hold until read, then refresh
    setb(1, 3, 1'b0); tick(4);
    rd(1);
    check("R3 held value", rd_data, 7'h08);
    check("R4 flag cleared", irq_flag, 0);
    rd(1);
    check("R4 refreshed", rd_data, 7'h00);

    // two channels pending
    setb(0, 1, 1'b1); setb(2, 6, 1'b1); tick(4);
    check("R5 flag set", irq_flag, 1);
    rd(0);
    check("R5 flag after one read", irq_flag, 1);
    check("R5 rd_data ch0", rd_data, 7'h03);
    rd(2);
    check("R5 flag after all reads", irq_flag, 0);
    check("R5 rd_data ch2", rd_data, 7'h40);

    // change landing on the read edge
    setb(3, 2, 1'b1); tick(4);
    setb(3, 4, 1'b1); tick(2);
    rd(3);
    check("R9 flag stays", irq_flag, 1);
    check("R9 rd_data", rd_data, 7'h04);
    rd(3);
    check("R9 flag cleared", irq_flag, 0);
    check("R9 relatched value", rd_data, 7'h14);

    // masking a latched bit
    setb(0, 5, 1'b1); tick(4);
    check("R10 flag set", irq_flag, 1);
    wmask(7'h20);
    check("R10 masked out", irq_flag, 0);
    wmask('0);
    check("R10 counted again", irq_flag, 1);
    rd(0);
    check("R10 rd_data", rd_data, 7'h23);
    check("R10 flag cleared", irq_flag, 0);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 4 == 0) live[$urandom_range(W-1)] ^= 1'b1;
      rd_stb = ($urandom % 6 == 0);
      rd_ch = 2'($urandom % 4);
      mask_we = ($urandom % 40 == 0);
      mask_wdata = NB'($urandom & $urandom);
      tick(1);
    end
    rd_stb = 1'b0; mask_we = 1'b0;
    tick(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule